// File: doc/BRIEF.md
# Machine-Cycle Timing and Reset Qualifier

This block sits beside a small 8-bit processor core and turns the raw oscillator clock into the core's machine-cycle timing. A static select input chooses how many oscillator clocks make up one machine cycle: 12, 4 or 1. The block emits a strobe one oscillator clock wide on the last clock of every machine cycle. The core uses that strobe to advance its internal sequencing.

The block also watches the board's reset pin. The pin is active high and normally low, and it is treated as asynchronous. It first passes through a two-flop synchronizer. It is honoured only after it has stayed high for two whole machine cycles, which is 2N oscillator clocks where N is the selected cycle length. A shorter pulse is discarded, and any low gap restarts the count. Once the pin qualifies, the internal core reset asserts and a one-clock request tells the memory wrapper to clear the internal RAM. Core reset stays high while the pin stays high. It releases on the first machine-cycle boundary after the synchronized pin has gone low.

The block also presents the values the core registers take at reset, so the core loads them while core reset is high. A separate active-low power-up input brings the block's own flops to a known state: the counter is cleared and core reset is held.

Top module: `mcyc_rst_gen`

## Requirements
- R1: The cycle select `cyc_sel` sets the machine-cycle length N: 2'b00 gives 12, 2'b01 gives 4, 2'b10 gives 1 and 2'b11 gives 12. `mc_stb` is high for exactly one oscillator clock in every N, so it is high on every clock when N is 1.
- R2: After power-up release, the cycle counter starts at zero. The first `mc_stb` is high during the N-th oscillator clock, which is the last clock of the first machine cycle.
- R3: When the reset pin has been high for 2N consecutive oscillator clocks as seen after synchronization, `core_rst` asserts. A pin pulse of 2N-1 clocks or fewer leaves `core_rst` low.
- R4: A pin low for even one clock restarts qualification. Two pulses of 2N-1 clocks separated by one low clock are ignored.
- R5: `core_rst` stays high while the synchronized pin is high. It falls only on the clock edge that ends a cycle marked by `mc_stb` once the synchronized pin is low.
- R6: Each qualification of the pin produces exactly one pulse on `ram_clr_req`, one oscillator clock wide and coincident with `core_rst` being high.
- R7: The reset-value outputs are constant: `rv_pc` = 16'h0000, `rv_acc` = `rv_b` = `rv_psw` = 8'h00, `rv_sp` = 8'h07 and `rv_dptr` = 16'h0000.
- R8: While and just after `por_n` is low, `core_rst` is 1 and `ram_clr_req` is 0. With the pin low, `core_rst` then releases on the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| por_n | input | 1 | Active-low power-up initialisation of the block's flops |
| rst_pin | input | 1 | Asynchronous active-high reset pin |
| cyc_sel | input | 2 | Static machine-cycle length select |
| mc_stb | output | 1 | One-clock strobe on the last clock of each machine cycle |
| core_rst | output | 1 | Synchronous internal reset for the core |
| ram_clr_req | output | 1 | One-clock request to clear internal RAM |
| rv_pc | output | 16 | Program counter reset value |
| rv_acc | output | 8 | Accumulator reset value |
| rv_b | output | 8 | B register reset value |
| rv_psw | output | 8 | Status word reset value |
| rv_sp | output | 8 | Stack pointer reset value |
| rv_dptr | output | 16 | Data pointer reset value |

## Verification
On every clock, the assertions check the following:
- The strobe is never high on two clocks in a row unless the cycle length is 1.
- `core_rst` rises only after the synchronized pin was high.
- `core_rst` holds while the pin is high and falls only after a strobe with the pin low.
- The RAM-clear request fires only with core reset asserted.

Some behaviours can only be shown by the bench's directed scenarios, because each depends on an exact count of clocks under a chosen mode:
- the exact strobe spacing and the position of the first strobe for each select value;
- the 2N versus 2N-1 qualification boundary;
- the restart of qualification after a single-clock gap;
- the single RAM-clear pulse per qualification.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
   typedef enum logic [1:0] {
      CYC_SLOW = 2'b00,
      CYC_MID  = 2'b01,
      CYC_FAST = 2'b10,
      CYC_ALT  = 2'b11
   } cyc_sel_e;

   localparam logic [15:0] INIT_PC   = 16'h0000;
   localparam logic [7:0]  INIT_ACC  = 8'h00;
   localparam logic [7:0]  INIT_B    = 8'h00;
   localparam logic [7:0]  INIT_PSW  = 8'h00;
   localparam logic [7:0]  INIT_SP   = 8'h07;
   localparam logic [15:0] INIT_DPTR = 16'h0000;
endpackage

// File: rtl/mcyc_divider.sv
module mcyc_divider #(
   parameter int SLOW_LEN = 12,
   parameter int MID_LEN  = 4,
   parameter int FAST_LEN = 1,
   localparam int LW = $clog2(SLOW_LEN + 1)
) (
   input  logic          clk_osc,
   input  logic          por_n,
   input  logic [1:0]    cyc_sel,
   output logic          mc_stb,
   output logic [LW-1:0] cyc_len
);
   import mcyc_pkg::*;

   always_comb begin
      case (cyc_sel_e'(cyc_sel))
         CYC_MID:  cyc_len = LW'(MID_LEN);
         CYC_FAST: cyc_len = LW'(FAST_LEN);
         default:  cyc_len = LW'(SLOW_LEN);
      endcase
   end

   generate
      if (SLOW_LEN == 1) begin : g_nodiv
         assign mc_stb = 1'b1;
      end else begin : g_div
         logic [LW-1:0] cnt_q;
         logic [LW-1:0] last_idx;
         assign last_idx = cyc_len - LW'(1);
         assign mc_stb   = (cnt_q >= last_idx);

         always_ff @(posedge clk_osc or negedge por_n) begin
            if (!por_n)      cnt_q <= '0;
            else if (mc_stb) cnt_q <= '0;
            else             cnt_q <= cnt_q + LW'(1);
         end

         // R1: strobe is one clock wide unless the cycle is one clock long
         assert_strobe_gap_R1: assert property (@(posedge clk_osc) disable iff (!por_n)
            (mc_stb && cyc_len != LW'(1) && $stable(cyc_sel)) |=> !mc_stb);
      end
   endgenerate
endmodule

// File: rtl/mcyc_sync.sv
module mcyc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_osc,
   input  logic por_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("mcyc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_osc or negedge por_n) begin
      if (!por_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mcyc_qualifier.sv
module mcyc_qualifier #(
   parameter int LW     = 4,
   parameter int MAXLEN = 12,
   localparam int HW = $clog2(2 * MAXLEN + 1)
) (
   input  logic          clk_osc,
   input  logic          por_n,
   input  logic          pin_s,
   input  logic          mc_stb,
   input  logic [LW-1:0] cyc_len,
   output logic          core_rst,
   output logic          ram_clr_req
);
   logic [HW-1:0] hold_q;
   logic [HW-1:0] span;
   logic          qualify;

   assign span    = HW'(cyc_len) << 1;
   assign qualify = pin_s && (hold_q == span - HW'(1));

   always_ff @(posedge clk_osc or negedge por_n) begin
      if (!por_n)             hold_q <= '0;
      else if (!pin_s)        hold_q <= '0;
      else if (hold_q < span) hold_q <= hold_q + HW'(1);
   end

   always_ff @(posedge clk_osc or negedge por_n) begin
      if (!por_n) begin
         core_rst    <= 1'b1;
         ram_clr_req <= 1'b0;
      end else begin
         ram_clr_req <= qualify;
         if (qualify)                       core_rst <= 1'b1;
         else if (!pin_s && mc_stb)         core_rst <= 1'b0;
      end
   end

   // R3: reset rises only with the synchronized pin high
   assert_rise_needs_pin_R3: assert property (@(posedge clk_osc) disable iff (!por_n)
      $rose(core_rst) |-> $past(pin_s));
   // R5: held while pin high
   assert_hold_R5: assert property (@(posedge clk_osc) disable iff (!por_n)
      (core_rst && pin_s) |=> core_rst);
   // R5: release only at a cycle boundary with pin low
   assert_release_on_strobe_R5: assert property (@(posedge clk_osc) disable iff (!por_n)
      $fell(core_rst) |-> ($past(mc_stb) && !$past(pin_s)));
   // R6: clear request only accompanies asserted reset
   assert_clr_pulse_R6: assert property (@(posedge clk_osc) disable iff (!por_n)
      ram_clr_req |-> core_rst);
endmodule

// File: rtl/mcyc_rst_gen.sv
module mcyc_rst_gen #(
   parameter int SLOW_LEN    = 12,
   parameter int MID_LEN     = 4,
   parameter int FAST_LEN    = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk_osc,
   input  logic        por_n,
   input  logic        rst_pin,
   input  logic [1:0]  cyc_sel,
   output logic        mc_stb,
   output logic        core_rst,
   output logic        ram_clr_req,
   output logic [15:0] rv_pc,
   output logic [7:0]  rv_acc,
   output logic [7:0]  rv_b,
   output logic [7:0]  rv_psw,
   output logic [7:0]  rv_sp,
   output logic [15:0] rv_dptr
);
   import mcyc_pkg::*;

   localparam int LW = $clog2(SLOW_LEN + 1);

   generate
      if (FAST_LEN < 1 || MID_LEN < FAST_LEN || SLOW_LEN < MID_LEN) begin : g_bad
         $error("mcyc_rst_gen: cycle lengths must satisfy 1 <= FAST <= MID <= SLOW");
      end
   endgenerate

   logic [LW-1:0] cyc_len;
   logic          pin_s;

   mcyc_divider #(
      .SLOW_LEN(SLOW_LEN), .MID_LEN(MID_LEN), .FAST_LEN(FAST_LEN)
   ) u_div (
      .clk_osc(clk_osc), .por_n(por_n), .cyc_sel(cyc_sel),
      .mc_stb(mc_stb), .cyc_len(cyc_len)
   );

   mcyc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_osc(clk_osc), .por_n(por_n), .d_async(rst_pin), .q_sync(pin_s)
   );

   mcyc_qualifier #(.LW(LW), .MAXLEN(SLOW_LEN)) u_qual (
      .clk_osc(clk_osc), .por_n(por_n), .pin_s(pin_s), .mc_stb(mc_stb),
      .cyc_len(cyc_len), .core_rst(core_rst), .ram_clr_req(ram_clr_req)
   );

   // R7: constant reset-time register values
   assign rv_pc   = INIT_PC;
   assign rv_acc  = INIT_ACC;
   assign rv_b    = INIT_B;
   assign rv_psw  = INIT_PSW;
   assign rv_sp   = INIT_SP;
   assign rv_dptr = INIT_DPTR;
endmodule

// File: tb/mcyc_rst_gen_bench.sv
`timescale 1ns/1ps
module mcyc_rst_gen_bench;
   logic        clk_osc = 1'b0;
   logic        por_n   = 1'b0;
   logic        rst_pin = 1'b0;
   logic [1:0]  cyc_sel = 2'b00;
   logic        mc_stb, core_rst, ram_clr_req;
   logic [15:0] rv_pc, rv_dptr;
   logic [7:0]  rv_acc, rv_b, rv_psw, rv_sp;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk_osc = ~clk_osc;

   mcyc_rst_gen u_mcyc_rst_gen (
      .clk_osc(clk_osc), .por_n(por_n), .rst_pin(rst_pin), .cyc_sel(cyc_sel),
      .mc_stb(mc_stb), .core_rst(core_rst), .ram_clr_req(ram_clr_req),
      .rv_pc(rv_pc), .rv_acc(rv_acc), .rv_b(rv_b), .rv_psw(rv_psw),
      .rv_sp(rv_sp), .rv_dptr(rv_dptr)
   );

   function automatic int len_of(input logic [1:0] m);
      return (m == 2'b01) ? 4 : (m == 2'b10) ? 1 : 12;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // R8 and R2: power-up state and first strobe position
   task automatic power_up(input logic [1:0] m);
      int n;
      int first;
      n = len_of(m);
      @(negedge clk_osc);
      por_n = 1'b0; rst_pin = 1'b0; cyc_sel = m;
      repeat (3) @(negedge clk_osc);
      por_n = 1'b1;
      check(core_rst == 1'b1, "R8 core_rst at power-up", int'(core_rst), 1);
      check(ram_clr_req == 1'b0, "R8 ram_clr_req at power-up", int'(ram_clr_req), 0);
      first = -1;
      for (int j = 0; j < 16 && first < 0; j++) begin
         if (j > 0) @(negedge clk_osc);
         if (mc_stb) first = j;
      end
      check(first == n - 1, "R2 first strobe index", first, n - 1);
      repeat (n + 3) @(negedge clk_osc);
      check(core_rst == 1'b0, "R8 release after power-up", int'(core_rst), 0);
   endtask

   // R1: strobe spacing and width
   task automatic t_strobe(input logic [1:0] m);
      int n;
      int gap;
      n = len_of(m);
      power_up(m);
      while (!mc_stb) @(negedge clk_osc);
      @(negedge clk_osc);
      if (n > 1) check(mc_stb == 1'b0, "R1 strobe width", int'(mc_stb), 0);
      gap = 1;
      while (!mc_stb && gap < 40) begin
         @(negedge clk_osc);
         gap++;
      end
      check(gap == n, "R1 strobe spacing", gap, n);
   endtask

   // R3: pulse one clock short of qualification is ignored
   // R4: restart after a single low clock
   task automatic t_short(input logic [1:0] m, input bit with_gap);
      int n;
      int seen_rst;
      int pulses;
      n = len_of(m);
      power_up(m);
      seen_rst = 0; pulses = 0;
      rst_pin = 1'b1;
      repeat (2 * n - 1) @(negedge clk_osc);
      rst_pin = 1'b0;
      if (with_gap) begin
         @(negedge clk_osc);
         rst_pin = 1'b1;
         repeat (2 * n - 1) begin
            @(negedge clk_osc);
            if (core_rst) seen_rst++;
            if (ram_clr_req) pulses++;
         end
         rst_pin = 1'b0;
      end
      repeat (2 * n + 8) begin
         @(negedge clk_osc);
         if (core_rst) seen_rst++;
         if (ram_clr_req) pulses++;
      end
      if (with_gap) begin
         check(seen_rst == 0, "R4 split pulse leaves core_rst low", seen_rst, 0);
         check(pulses == 0, "R4 split pulse makes no clear", pulses, 0);
      end else begin
         check(seen_rst == 0, "R3 short pulse leaves core_rst low", seen_rst, 0);
         check(pulses == 0, "R3 short pulse makes no clear", pulses, 0);
      end
   endtask

   // R3, R5, R6: qualified pulse, hold and release at boundary
   task automatic t_long(input logic [1:0] m, input int extra);
      int n;
      int pulses;
      int fell_at;
      bit prev_stb;
      bit stb_at_fall;
      n = len_of(m);
      power_up(m);
      pulses = 0; fell_at = -1; stb_at_fall = 1'b0;
      rst_pin = 1'b1;
      repeat (2 * n + 2 + extra) begin
         @(negedge clk_osc);
         if (ram_clr_req) pulses++;
      end
      check(core_rst == 1'b1, "R3 qualified pulse asserts core_rst", int'(core_rst), 1);
      check(core_rst == 1'b1, "R5 core_rst held while pin high", int'(core_rst), 1);
      rst_pin = 1'b0;
      prev_stb = mc_stb;
      for (int j = 0; j < 3 * n + 8; j++) begin
         @(negedge clk_osc);
         if (ram_clr_req) pulses++;
         if (fell_at < 0 && !core_rst) begin
            fell_at = j;
            stb_at_fall = prev_stb;
         end
         prev_stb = mc_stb;
      end
      check(fell_at >= 1, "R5 release after pin low", fell_at, 1);
      check(stb_at_fall == 1'b1, "R5 release on strobe", int'(stb_at_fall), 1);
      check(pulses == 1, "R6 one clear pulse", pulses, 1);
   endtask

   task automatic t_values();
      check(rv_pc == 16'h0000, "R7 pc", int'(rv_pc), 0);
      check(rv_acc == 8'h00, "R7 acc", int'(rv_acc), 0);
      check(rv_b == 8'h00, "R7 b", int'(rv_b), 0);
      check(rv_psw == 8'h00, "R7 psw", int'(rv_psw), 0);
      check(rv_sp == 8'h07, "R7 sp", int'(rv_sp), 7);
      check(rv_dptr == 16'h0000, "R7 dptr", int'(rv_dptr), 0);
   endtask

   initial begin
      for (int m = 0; m < 4; m++) t_strobe(2'(m));
      for (int m = 0; m < 3; m++) begin
         t_short(2'(m), 1'b0);
         t_short(2'(m), 1'b1);
         t_long(2'(m), 0);
         t_long(2'(m), 7);
      end
      t_values();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule